// File: doc/BRIEF.md
# Dual-Mode Link Integrity Monitor

This block sits behind the code-group decoder of a 100 Mbps twisted-pair receiver. It looks at one received symbol per clock and decides whether the link is usable. Three flags come with each symbol: a valid strobe, a symbol-error flag and an idle flag. Whichever rule is selected, the link comes up only after a clean block of symbols. Once the link is up, one of two rules can take it down. The standard rule drops the link when a block has too many errors. The enhanced rule drops the link when no complete run of idle symbols arrives before a timeout, and it ignores error counts.

When the link falls, the block does three things. It pulls a sticky status bit low, fires a one-cycle interrupt pulse, and, if auto-negotiation is on, asks the negotiation engine to start over. It also tells the transmit path what to send. Frames and idles go out while the link is up. Link pulse bursts go out while it is down, unless a diagnostic override is set with auto-negotiation switched off.

Top module: `link_guard`

## Requirements
- R1: During reset and just after it, linkUp, linkStat, linkIrq and renegReq are all 0, and txData is 0 while diagOverride is 0.
- R2: Valid symbols are grouped into back-to-back, non-overlapping blocks of WIN_LEN (1024), counted from reset. If the link is down and a block ends with fewer than ERR_LIMIT (64) errored symbols, linkUp is 1 from the clock edge that takes in the block's last symbol.
- R3: A block with exactly ERR_LIMIT errors changes nothing. It does not raise a down link, and it does not drop an up link in standard mode.
- R4: In standard mode (modeEnh = 0), an up link drops at the clock edge that takes in the last symbol of a block with more than ERR_LIMIT errors.
- R5: The error count saturates and never wraps. A block in which every symbol is errored counts as too many errors: it never raises the link and it drops an up link in standard mode.
- R6: In enhanced mode (modeEnh = 1), error counts never drop the link. An up link drops exactly TIMEOUT clock cycles after it came up, or after its last completed idle run, when no completed run comes in between.
- R7: An idle run is IDLE_RUN (12) valid symbols with symIdle = 1 and no valid non-idle symbol among them. A cycle with symValid = 0 neither extends nor breaks a run. Completing a run restarts the enhanced-mode timeout.
- R8: Every link drop, in either mode, gives exactly one cycle of linkIrq = 1. That cycle is the first cycle with linkUp = 0.
- R9: linkStat goes to 0 on every drop and stays 0, even if the link comes back, until a statRead pulse. The edge at which statRead is sampled loads the link state that this edge produces.
- R10: renegReq pulses together with linkIrq when anEn = 1, and stays 0 when anEn = 0.
- R11: txData = 1 (send frames or idle) when linkUp = 1, or when diagOverride = 1 and anEn = 0. Otherwise txData = 0 (send link pulse bursts).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | A decoded symbol is present this cycle |
| symErr | input | 1 | The present symbol is invalid or errored |
| symIdle | input | 1 | The present symbol is an idle code-group |
| modeEnh | input | 1 | 0 = error-rate drop rule, 1 = idle-timeout drop rule |
| anEn | input | 1 | Auto-negotiation is enabled |
| diagOverride | input | 1 | Allow data transmission with the link down |
| statRead | input | 1 | Read strobe that refreshes the sticky status bit |
| linkUp | output | 1 | Current link state |
| linkStat | output | 1 | Sticky link status, held low after a failure |
| linkIrq | output | 1 | One-cycle pulse on link failure |
| renegReq | output | 1 | One-cycle request to restart auto-negotiation |
| txData | output | 1 | 1 = send frames or idle, 0 = send link pulse bursts |

## Verification
The checker looks at every cycle for properties that span the ports. These are the single-cycle shape of the interrupt and where it sits against the falling link, the tie between the renegotiation request and the interrupt and anEn, the transmit-permit rule, and the sticky status never showing up while the link is down. Other behaviours depend on exact counts of symbols and cycles, and only the directed scenarios can show them. These are the block-boundary thresholds at 63, 64 and 65 errors, saturation on a block full of errors, the exact cycle of the idle timeout, and which idle patterns restart that timeout.

// File: rtl/link_guard_pkg.sv
package link_guard_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic timerRun;   // idle timeout may advance
  } guardCtl_t;

  // events from datapath to control
  typedef struct packed {
    logic winGood;    // block closed below the error limit
    logic winBad;     // block closed above the error limit
    logic runDone;    // an idle run just completed
    logic timeUp;     // idle timeout expires this cycle
  } guardEvt_t;

endpackage

// File: rtl/link_guard_dp.sv
module link_guard_dp
  import link_guard_pkg::*;
#(
  parameter int WIN_LEN   = 1024,
  parameter int ERR_LIMIT = 64,
  parameter int IDLE_RUN  = 12,
  parameter int TIMEOUT   = 25000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      symValid,
  input  logic      symErr,
  input  logic      symIdle,
  input  guardCtl_t ctl,
  output guardEvt_t evt
);

  localparam int SYM_W = $clog2(WIN_LEN);
  localparam int ERR_W = $clog2(ERR_LIMIT) + 1;
  localparam int RUN_W = $clog2(IDLE_RUN + 1);
  localparam int TMR_W = $clog2(TIMEOUT + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};
  localparam logic [ERR_W-1:0] ERR_LIM = ERR_W'(ERR_LIMIT);

  logic [SYM_W-1:0] symCnt;
  logic [ERR_W-1:0] errCnt, errNext;
  logic [RUN_W-1:0] runCnt;
  logic [TMR_W-1:0] tmrCnt;
  logic lastSym, addErr, runHit;

  assign lastSym = symValid && (symCnt == SYM_W'(WIN_LEN - 1));
  assign addErr  = symValid && symErr;
  assign errNext = (addErr && errCnt != ERR_MAX) ? errCnt + 1'b1 : errCnt;
  assign runHit  = symValid && symIdle && (runCnt == RUN_W'(IDLE_RUN - 1));

  // block position and saturating error tally
  always_ff @(posedge clk) begin
    if (!rstN) begin
      symCnt <= '0;
      errCnt <= '0;
    end else if (lastSym) begin
      symCnt <= '0;
      errCnt <= '0;
    end else begin
      if (symValid) symCnt <= symCnt + 1'b1;
      errCnt <= errNext;
    end
  end

  // consecutive idle run length
  always_ff @(posedge clk) begin
    if (!rstN) runCnt <= '0;
    else if (symValid) begin
      if (!symIdle || runHit) runCnt <= '0;
      else                    runCnt <= runCnt + 1'b1;
    end
  end

  // idle timeout, restarted by each completed run
  always_ff @(posedge clk) begin
    if (!rstN || !ctl.timerRun || runHit) tmrCnt <= '0;
    else if (tmrCnt != TMR_W'(TIMEOUT - 1)) tmrCnt <= tmrCnt + 1'b1;
  end

  always_comb begin
    evt.winGood = lastSym && (errNext < ERR_LIM);
    evt.winBad  = lastSym && (errNext > ERR_LIM);
    evt.runDone = runHit;
    evt.timeUp  = ctl.timerRun && !runHit && (tmrCnt == TMR_W'(TIMEOUT - 1));
  end

endmodule

// File: rtl/link_guard_ctl.sv
module link_guard_ctl
  import link_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeEnh,
  input  logic      anEn,
  input  logic      diagOverride,
  input  logic      statRead,
  input  guardEvt_t evt,
  output guardCtl_t ctl,
  output logic      linkUp,
  output logic      linkStat,
  output logic      linkIrq,
  output logic      renegReq,
  output logic      txData
);

  logic dropNow, upNext;

  assign dropNow = linkUp && (modeEnh ? evt.timeUp : evt.winBad);
  assign upNext  = linkUp ? !dropNow : evt.winGood;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkUp   <= 1'b0;
      linkStat <= 1'b0;
      linkIrq  <= 1'b0;
      renegReq <= 1'b0;
    end else begin
      linkUp   <= upNext;
      linkIrq  <= dropNow;
      renegReq <= dropNow && anEn;
      if (dropNow)       linkStat <= 1'b0;
      else if (statRead) linkStat <= upNext;
    end
  end

  // evt.runDone is consumed inside the datapath timer
  logic unusedRun;
  assign unusedRun = evt.runDone;

  assign ctl.timerRun = linkUp && modeEnh;
  assign txData       = linkUp || (diagOverride && !anEn);

endmodule

// File: rtl/link_guard.sv
module link_guard
  import link_guard_pkg::*;
#(
  parameter int WIN_LEN   = 1024,
  parameter int ERR_LIMIT = 64,
  parameter int IDLE_RUN  = 12,
  parameter int TIMEOUT   = 25000
) (
  input  logic clk,
  input  logic rstN,
  input  logic symValid,
  input  logic symErr,
  input  logic symIdle,
  input  logic modeEnh,
  input  logic anEn,
  input  logic diagOverride,
  input  logic statRead,
  output logic linkUp,
  output logic linkStat,
  output logic linkIrq,
  output logic renegReq,
  output logic txData
);

  guardCtl_t ctl;
  guardEvt_t evt;

  link_guard_dp #(
    .WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT),
    .IDLE_RUN(IDLE_RUN), .TIMEOUT(TIMEOUT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symErr(symErr),
    .symIdle(symIdle), .ctl(ctl), .evt(evt)
  );

  link_guard_ctl u_ctl (
    .clk(clk), .rstN(rstN), .modeEnh(modeEnh), .anEn(anEn),
    .diagOverride(diagOverride), .statRead(statRead), .evt(evt),
    .ctl(ctl), .linkUp(linkUp), .linkStat(linkStat), .linkIrq(linkIrq),
    .renegReq(renegReq), .txData(txData)
  );

endmodule

// File: rtl/link_guard_chk.sv
module link_guard_chk (
  input logic clk,
  input logic rstN,
  input logic anEn,
  input logic diagOverride,
  input logic linkUp,
  input logic linkStat,
  input logic linkIrq,
  input logic renegReq,
  input logic txData
);

  // R8: interrupt lasts one cycle
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    linkIrq |=> !linkIrq);

  // R8: interrupt marks the first cycle of a down link
  assert_irq_on_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    linkIrq |-> (!linkUp && $past(linkUp)));

  // R10: renegotiation only alongside the interrupt
  assert_reneg_with_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    renegReq |-> linkIrq);

  // R10: renegotiation only when auto-negotiation was enabled
  assert_reneg_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    renegReq |-> $past(anEn));

  // R11: an up link always permits data
  assert_tx_when_up_R11: assert property (@(posedge clk) disable iff (!rstN)
    linkUp |-> txData);

  // R11: with negotiation on, a down link forces bursts
  assert_burst_when_down_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!linkUp && anEn) |-> !txData);

  // R11: override works with negotiation off
  assert_override_R11: assert property (@(posedge clk) disable iff (!rstN)
    (diagOverride && !anEn) |-> txData);

  // R9: sticky status never reports an up link that is down
  assert_stat_needs_up_R9: assert property (@(posedge clk) disable iff (!rstN)
    linkStat |-> linkUp);

  // R9: a drop clears the sticky status
  assert_stat_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(linkUp) |-> !linkStat);

endmodule

bind link_guard link_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .anEn(anEn), .diagOverride(diagOverride),
  .linkUp(linkUp), .linkStat(linkStat), .linkIrq(linkIrq),
  .renegReq(renegReq), .txData(txData)
);

// File: tb/sim_link_guard.sv
module sim_link_guard;

  localparam int WIN = 1024;
  localparam int LIM = 64;
  localparam int TMO = 2000;

  logic clk = 1'b0;
  logic rstN, symValid, symErr, symIdle, modeEnh, anEn, diagOverride, statRead;
  logic linkUp, linkStat, linkIrq, renegReq, txData;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  link_guard #(.WIN_LEN(WIN), .ERR_LIMIT(LIM), .IDLE_RUN(12), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symErr(symErr),
    .symIdle(symIdle), .modeEnh(modeEnh), .anEn(anEn),
    .diagOverride(diagOverride), .statRead(statRead), .linkUp(linkUp),
    .linkStat(linkStat), .linkIrq(linkIrq), .renegReq(renegReq), .txData(txData)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic sendSym(input logic v, input logic e, input logic i);
    @(negedge clk);
    symValid = v; symErr = e; symIdle = i;
    @(posedge clk); #1;
  endtask

  task automatic quiet(input int n);
    for (int k = 0; k < n; k++) sendSym(1'b0, 1'b0, 1'b0);
  endtask

  task automatic sendWin(input int nErr, input logic idl);
    for (int k = 0; k < WIN; k++) sendSym(1'b1, k < nErr, idl);
  endtask

  task automatic readStat();
    @(negedge clk); statRead = 1'b1; symValid = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); statRead = 1'b0;
  endtask

  task automatic doReset(input logic mode, input logic an);
    @(negedge clk);
    rstN = 1'b0; symValid = 0; symErr = 0; symIdle = 0; statRead = 0;
    diagOverride = 0; modeEnh = mode; anEn = an;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic tReset();
    doReset(1'b0, 1'b1);
    #1;
    chk("R1 linkUp", linkUp, 1'b0);
    chk("R1 linkStat", linkStat, 1'b0);
    chk("R1 linkIrq", linkIrq, 1'b0);
    chk("R1 renegReq", renegReq, 1'b0);
    chk("R1 txData", txData, 1'b0);
  endtask

  task automatic tThresholds();
    doReset(1'b0, 1'b1);
    sendWin(LIM, 1'b0);
    chk("R3 64 errors keep link down", linkUp, 1'b0);
    sendWin(LIM - 1, 1'b0);
    chk("R2 63 errors raise link", linkUp, 1'b1);
    sendWin(LIM, 1'b0);
    chk("R3 64 errors keep link up", linkUp, 1'b1);
    sendWin(LIM + 1, 1'b0);
    chk("R4 65 errors drop link", linkUp, 1'b0);
    chk("R8 irq on drop", linkIrq, 1'b1);
    chk("R10 reneg with anEn", renegReq, 1'b1);
    chk("R9 stat low after drop", linkStat, 1'b0);
    quiet(1);
    chk("R8 irq one cycle", linkIrq, 1'b0);
    chk("R10 reneg one cycle", renegReq, 1'b0);
  endtask

  task automatic tNoReneg();
    doReset(1'b0, 1'b0);
    sendWin(0, 1'b0);
    chk("R2 clean block raises link", linkUp, 1'b1);
    sendWin(LIM + 1, 1'b0);
    chk("R4 drop with anEn off", linkUp, 1'b0);
    chk("R8 irq with anEn off", linkIrq, 1'b1);
    chk("R10 no reneg with anEn off", renegReq, 1'b0);
  endtask

  task automatic tSaturate();
    doReset(1'b0, 1'b1);
    sendWin(WIN, 1'b0);
    chk("R5 all-error block keeps link down", linkUp, 1'b0);
    sendWin(0, 1'b0);
    chk("R5 link raised by clean block", linkUp, 1'b1);
    sendWin(WIN, 1'b0);
    chk("R5 all-error block drops link", linkUp, 1'b0);
  endtask

  task automatic tStatus();
    doReset(1'b0, 1'b1);
    sendWin(0, 1'b0);
    chk("R9 stat stays low until read", linkStat, 1'b0);
    readStat();
    chk("R9 read loads up state", linkStat, 1'b1);
    sendWin(LIM + 1, 1'b0);
    chk("R9 drop clears stat", linkStat, 1'b0);
    sendWin(0, 1'b0);
    chk("R9 relink keeps stat latched low", linkStat, 1'b0);
    readStat();
    chk("R9 second read sets stat", linkStat, 1'b1);
  endtask

  task automatic tTimeout();
    doReset(1'b1, 1'b1);
    sendWin(0, 1'b0);
    chk("R2 up in enhanced mode", linkUp, 1'b1);
    quiet(TMO - 1);
    chk("R6 still up one cycle before timeout", linkUp, 1'b1);
    quiet(1);
    chk("R6 drops at timeout", linkUp, 1'b0);
    chk("R8 irq on timeout", linkIrq, 1'b1);
    chk("R10 reneg on timeout", renegReq, 1'b1);
  endtask

  task automatic tEnhErrors();
    doReset(1'b1, 1'b1);
    sendWin(0, 1'b1);
    for (int k = 0; k < WIN; k++) sendSym(1'b1, k < 200, k >= 200);
    chk("R6 errors ignored in enhanced mode", linkUp, 1'b1);
  endtask

  task automatic tRearm();
    doReset(1'b1, 1'b1);
    sendWin(0, 1'b0);
    quiet(TMO - 20);
    for (int k = 0; k < 12; k++) sendSym(1'b1, 1'b0, 1'b1);
    quiet(TMO - 5);
    chk("R7 full run restarts timeout", linkUp, 1'b1);
    quiet(10);
    chk("R6 drop after restarted timeout", linkUp, 1'b0);
  endtask

  task automatic tBrokenRun();
    doReset(1'b1, 1'b1);
    sendWin(0, 1'b0);
    quiet(TMO - 30);
    for (int k = 0; k < 11; k++) sendSym(1'b1, 1'b0, 1'b1);
    sendSym(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 11; k++) sendSym(1'b1, 1'b0, 1'b1);
    chk("R7 up before broken-run timeout", linkUp, 1'b1);
    quiet(10);
    chk("R7 broken run does not restart", linkUp, 1'b0);
  endtask

  task automatic tGapRun();
    doReset(1'b1, 1'b1);
    sendWin(0, 1'b0);
    quiet(TMO - 20);
    for (int k = 0; k < 6; k++) sendSym(1'b1, 1'b0, 1'b1);
    quiet(3);
    for (int k = 0; k < 6; k++) sendSym(1'b1, 1'b0, 1'b1);
    quiet(TMO - 5);
    chk("R7 invalid gap keeps run alive", linkUp, 1'b1);
  endtask

  task automatic tTransmit();
    doReset(1'b0, 1'b0);
    @(negedge clk); diagOverride = 1'b1; #1;
    chk("R11 override with anEn off", txData, 1'b1);
    @(negedge clk); anEn = 1'b1; #1;
    chk("R11 override blocked by anEn", txData, 1'b0);
    sendWin(0, 1'b0);
    chk("R11 data when up", txData, 1'b1);
    @(negedge clk); diagOverride = 1'b0;
  endtask

  initial begin
    rstN = 0; symValid = 0; symErr = 0; symIdle = 0;
    modeEnh = 0; anEn = 0; diagOverride = 0; statRead = 0;
    tReset();
    tThresholds();
    tNoReneg();
    tSaturate();
    tStatus();
    tTimeout();
    tEnhErrors();
    tRearm();
    tBrokenRun();
    tGapRun();
    tTransmit();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule